// File: doc/BRIEF.md
# Carry-save to serial binary converter

This block accepts a number kept in redundant sum/carry form, a sum vector plus a carry vector whose weight is doubled, and streams out the plain binary value of that number one bit per clock, least significant bit first. It never runs a full carry-propagate adder. A single half-adder row works through the pending pair one step per cycle while the result shifts out. Each step settles the lowest bit and halves what is left.

A producer that keeps partial results in carry-save form, such as a multiplier array or an accumulator tree, raises the load strobe for one cycle with both vectors. The binary value starts to appear in that same cycle. Each later cycle with the strobe low gives the next higher bit. A new load at any time drops whatever was still pending and starts the new value at its lowest bit.

Top module: `csbs_serializer`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the pending state is cleared. After reset, with `load_i` low, `bit_o` reads 0 on every cycle until the first load.
- R2: In any cycle where `load_i` is high, `bit_o` equals `sum_vec_i[0]` in that same cycle. Index 0 is the least significant bit of both input vectors.
- R3: The loaded value is X = `sum_vec_i` + 2·`carry_vec_i`. If the load happens at cycle t and `load_i` stays low for cycles t+1 through t+k, then `bit_o` at cycle t+k equals bit k of X, for every k from 1 to R+2.
- R4: After a load followed only by cycles with `load_i` low, `bit_o` is 0 at cycle t+k for every k greater than R+2, because X has no bits at or above position R+3.
- R5: A load that arrives while an earlier value is still streaming throws away the remaining bits of the earlier value. The output then follows R2 and R3 for the new value, counted from the new load cycle.
- R6: Reset has priority over load. If `load_i` is high in a cycle where `rst_n` is low, nothing is captured, and the bits that follow reset read 0 as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | One-cycle strobe that captures a new sum/carry pair |
| sum_vec_i | input | R+1 | Sum vector, weight 1 |
| carry_vec_i | input | R+1 | Carry vector, weight 2 |
| bit_o | output | 1 | Serial binary result, least significant bit first |

## Verification
The bench builds the block with R = 7, so each vector is 8 bits wide and a loaded value has at most 10 significant bits. With that width, an all-ones sum paired with an all-ones carry sends a carry through every stage of the register pair in under a dozen cycles. Every vector in the table is followed two bits past its top significant bit, so both the full ripple and the drain to zero fall within a short run. Directed cases reload in mid-stream, reset in mid-stream, and hold the load strobe high during reset.

// File: rtl/csbs_pkg.sv
// Shared definitions for the carry-save serializer.
// Assumes: nothing beyond the importing modules' own parameters.
package csbs_pkg;

    // Source of the next register contents.
    typedef enum logic {
        CSBS_SRC_STEP = 1'b0,   // result of the half-adder row, shifted
        CSBS_SRC_LOAD = 1'b1    // freshly presented sum/carry pair
    } csbs_src_e;

endpackage

// File: rtl/csbs_step.sv
// One half-adder step over the pending sum/carry registers.
// For each position below R the sum and carry bits are half-added. The
// top carry bit passes straight through to the top sum position, and the
// top output carry is tied to zero.
// Assumes: R >= 1; purely combinational.
module csbs_step #(
    parameter int R = 15
) (
    input  logic [R-1:0] sp_i,
    input  logic [R:0]   cp_i,
    output logic [R:0]   sq_o,
    output logic [R:0]   cq_o
);

    // Half-adder cells for the positions where both registers have a bit.
    for (genvar i = 0; i < R; i++) begin : g_cell
        assign sq_o[i] = sp_i[i] ^ cp_i[i];
        assign cq_o[i] = sp_i[i] & cp_i[i];
    end

    // Top position: only a carry bit exists, so it moves across unchanged.
    assign sq_o[R] = cp_i[R];
    assign cq_o[R] = 1'b0;

endmodule

// File: rtl/csbs_next_sel.sv
// Selects the next register contents: a fresh pair on load, otherwise the
// half-adder result shifted right by one position.
// Assumes: the caller has already settled the source selection.
module csbs_next_sel #(
    parameter int R = 15
) (
    input  csbs_pkg::csbs_src_e src_i,
    input  logic [R:0]          xs_i,
    input  logic [R:0]          xc_i,
    input  logic [R:0]          sq_i,
    input  logic [R:0]          cq_i,
    output logic [R-1:0]        sp_d_o,
    output logic [R:0]          cp_d_o
);
    import csbs_pkg::*;

    // Next-state mux; bit 0 of the sum side is dropped since it was output.
    always_comb begin
        if (src_i == CSBS_SRC_LOAD) begin
            sp_d_o = xs_i[R:1];
            cp_d_o = xc_i;
        end else begin
            sp_d_o = sq_i[R:1];
            cp_d_o = cq_i;
        end
    end

endmodule

// File: rtl/csbs_state.sv
// Pending sum/carry registers with synchronous active-low clear.
// Assumes: rst_n is synchronous to clk; reset outranks any update.
module csbs_state #(
    parameter int R = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [R-1:0] sp_d_i,
    input  logic [R:0]   cp_d_i,
    output logic [R-1:0] sp_q_o,
    output logic [R:0]   cp_q_o
);

    // Register update with clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q_o <= '0;
            cp_q_o <= '0;
        end else begin
            sp_q_o <= sp_d_i;
            cp_q_o <= cp_d_i;
        end
    end

    AST_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sp_q_o == '0 && cp_q_o == '0)); // R1

endmodule

// File: rtl/csbs_serializer.sv
// Carry-save to serial binary converter, top level.
// A load captures sum vector xs and carry vector xc (value xs + 2*xc) and
// emits bit 0 at once; each later cycle emits the next bit while a single
// half-adder row works through the pending pair.
// Assumes: R >= 1; load_i is sampled on the rising edge of clk.
module csbs_serializer #(
    parameter int R = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [R:0] sum_vec_i,
    input  logic [R:0] carry_vec_i,
    output logic       bit_o
);
    import csbs_pkg::*;

    localparam int VW = R + 2;   // width that holds sp + cp without loss

    logic [R-1:0] sp_q;
    logic [R:0]   cp_q;
    logic [R-1:0] sp_d;
    logic [R:0]   cp_d;
    logic [R:0]   sq;
    logic [R:0]   cq;
    csbs_src_e    src;

    // Choose the register source from the load strobe.
    always_comb src = load_i ? CSBS_SRC_LOAD : CSBS_SRC_STEP;

    csbs_step #(.R(R)) u_step (
        .sp_i (sp_q),
        .cp_i (cp_q),
        .sq_o (sq),
        .cq_o (cq)
    );

    csbs_next_sel #(.R(R)) u_sel (
        .src_i  (src),
        .xs_i   (sum_vec_i),
        .xc_i   (carry_vec_i),
        .sq_i   (sq),
        .cq_i   (cq),
        .sp_d_o (sp_d),
        .cp_d_o (cp_d)
    );

    csbs_state #(.R(R)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .sp_d_i (sp_d),
        .cp_d_i (cp_d),
        .sp_q_o (sp_q),
        .cp_q_o (cp_q)
    );

    // Serial output: the raw LSB on load, otherwise the settled low bit.
    always_comb bit_o = load_i ? sum_vec_i[0] : sq[0];

    // Value still owed to the output, and the value a load would leave.
    logic [VW-1:0] pend;
    logic [VW-1:0] load_rest;
    always_comb pend      = VW'(sp_q) + VW'(cp_q);
    always_comb load_rest = VW'(sum_vec_i[R:1]) + VW'(carry_vec_i);

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_i)) |-> (pend == $past(load_rest))); // R5

    AST_HALVE_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_i))
        |-> ({1'b0, $past(pend)} == ({pend, 1'b0} + (VW+1)'($past(bit_o))))); // R3

    AST_TOP_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_i)) |-> !cp_q[R]); // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && pend == '0) |-> !bit_o); // R1

endmodule

// File: tb/csbs_serializer_test.sv
module csbs_serializer_test;

    localparam int R     = 7;
    localparam int W     = R + 1;
    localparam int NB    = R + 5;   // bits observed per value
    localparam int NVEC  = 10;

    // Each entry: {sum vector, carry vector}.
    localparam logic [2*W-1:0] VEC [NVEC] = '{
        {8'h00, 8'h00}, {8'hFF, 8'h00}, {8'h00, 8'hFF}, {8'hFF, 8'hFF},
        {8'h55, 8'hAA}, {8'hAA, 8'h55}, {8'h01, 8'h7F}, {8'h80, 8'h80},
        {8'h3C, 8'hC3}, {8'hFF, 8'h01}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [R:0]   xs = '0;
    logic [R:0]   xc = '0;
    logic         xb;
    int           total = 0;
    int           bad = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    csbs_serializer #(.R(R)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .sum_vec_i   (xs),
        .carry_vec_i (xc),
        .bit_o       (xb)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    // Load a pair and check the first nbits output bits against xs + 2*xc.
    task automatic stream(input logic [R:0] s, input logic [R:0] c, input int nbits);
        int x;
        x = int'(s) + 2 * int'(c);
        @(negedge clk);
        load = 1'b1; xs = s; xc = c;
        #1 check("R2 load bit", xb, x[0]);
        for (int k = 1; k < nbits; k++) begin
            @(negedge clk);
            load = 1'b0; xs = ~s; xc = ~c;   // idle inputs must not matter
            #1;
            if (k <= R + 2) check($sformatf("R3 bit %0d", k), xb, x[k]);
            else            check($sformatf("R4 bit %0d", k), xb, 1'b0);
        end
    endtask

    task automatic expect_idle_zero(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            load = 1'b0;
            #1 check(tag, xb, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, no load yet
        expect_idle_zero("R1 after reset", 4);

        // Table walk: R2, R3, R4 per vector
        for (int v = 0; v < NVEC; v++)
            stream(VEC[v][2*W-1:W], VEC[v][W-1:0], NB);

        // R5: reload mid-stream, new value restarts at bit 0
        stream(8'hFF, 8'hFF, 3);
        stream(8'h12, 8'h34, NB);
        stream(8'h7E, 8'h81, 2);
        stream(8'h00, 8'h01, NB);
        // R5: back-to-back loads
        stream(8'hFF, 8'h00, 1);
        stream(8'h0F, 8'hF0, NB);

        // R1: reset in mid-stream clears pending bits
        stream(8'hFF, 8'hFF, 3);
        @(negedge clk);
        load = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 mid-stream reset", xb, 1'b0);
        expect_idle_zero("R1 drained", R + 3);

        // R6: load high during reset captures nothing
        @(negedge clk);
        rst_n = 1'b0; load = 1'b1; xs = '1; xc = '1;
        @(negedge clk);
        rst_n = 1'b1; load = 1'b0;
        #1 check("R6 reset beats load", xb, 1'b0);
        expect_idle_zero("R6 nothing captured", R + 3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule